// File: doc/BRIEF.md
# Dual-Read-Bus Register File

This block holds the general-purpose registers of a CPU whose datapath has two operand buses feeding the ALU and one result bus coming back from it. It has a configurable number of entries (eight by default) of configurable width (32 bits by default). Two read ports work independently. Each has a selector code and an enable. When a port is enabled, it presents the selected entry together with a drive-valid flag, so that a bus multiplexer outside the block can merge it with other sources. When a port is disabled, its data is zero and its flag is low.

A single write port loads the result-bus value into one entry on the rising clock edge. The target entry comes from a one-hot decode of a destination code, and the decode is gated by a write enable. Entry 0 has no storage and always reads as zero. The decoder output for code 0 drives nothing, so a write aimed at entry 0 changes nothing.

Top module: `dual_bus_regfile`

## Requirements
- R1: After a synchronous active-high reset, every entry reads as zero on both ports.
- R2: Entry 0 always reads as zero. A write with destination code 0 changes no entry.
- R3: With the write enable high and a destination code d in 1..7, entry d takes the write data at the rising edge. From the next cycle on it reads back that value.
- R4: With the write enable low, no entry changes, whatever the destination code and data are.
- R5: A write changes only the addressed entry. All other entries keep their values.
- R6: Read port A outputs the entry picked by its 3-bit selector, with its valid flag high, whenever its enable is high. When the enable is low, the data is zero and the flag is low.
- R7: Read port B behaves like port A, with its own selector and enable. Both ports may be enabled in the same cycle, with the same or different selectors.
- R8: A read of the entry being written in the same cycle returns the value held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 3 | Entry selector for read port A |
| rd_a_en | input | 1 | Read port A drive enable |
| rd_b_sel | input | 3 | Entry selector for read port B |
| rd_b_en | input | 1 | Read port B drive enable |
| wr_sel | input | 3 | Destination entry code |
| wr_en | input | 1 | Write enable |
| wr_data | input | 32 | Value from the result bus |
| rd_a_data | output | 32 | Port A data, zero when disabled |
| rd_a_vld | output | 1 | Port A drive-valid |
| rd_b_data | output | 32 | Port B data, zero when disabled |
| rd_b_vld | output | 1 | Port B drive-valid |

## Verification
The read paths are combinational, so a corrupted entry or a misrouted decoder line shows at the read ports in the very cycle after the faulty edge. It shows once either port selects the damaged entry. After every write the bench reads all entries through both ports. Because of this, a wrong-entry write, a missed write, or a write to entry 0 is caught within one cycle of the edge that caused it. Write data is varied per vector, so stuck or swapped bits also reach the compared outputs.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int unsigned RF_ENTRIES = 8;
    localparam int unsigned RF_WIDTH   = 32;
    localparam int unsigned RF_SELW    = $clog2(RF_ENTRIES);
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned SELW    = $clog2(ENTRIES)
) (
    input  logic [SELW-1:0]    sel,
    input  logic               en,
    output logic [ENTRIES-1:0] onehot
);
    always_comb begin
        onehot = '0;
        for (int i = 1; i < ENTRIES; i++) begin
            onehot[i] = en && (sel == SELW'(i));
        end
    end

    always_comb begin
        assert_wr_onehot_R3: assert (!$isunknown({en, sel}) -> $onehot0(onehot));
        assert_no_entry0_write_R2: assert (onehot[0] == 1'b0);
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned WIDTH   = 32,
    parameter int unsigned SELW    = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][WIDTH-1:0] regs,
    input  logic [SELW-1:0]               sel,
    input  logic                          en,
    output logic [WIDTH-1:0]              data,
    output logic                          vld
);
    always_comb begin
        vld  = en;
        data = en ? regs[sel] : '0;
    end

    always_comb begin
        assert_rd_idle_zero_R6: assert (en || data == '0);
    end
endmodule

// File: rtl/dual_bus_regfile.sv
module dual_bus_regfile
    import regfile_pkg::*;
#(
    parameter int unsigned ENTRIES = RF_ENTRIES,
    parameter int unsigned WIDTH   = RF_WIDTH,
    localparam int unsigned SELW   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SELW-1:0]  rd_a_sel,
    input  logic             rd_a_en,
    input  logic [SELW-1:0]  rd_b_sel,
    input  logic             rd_b_en,
    input  logic [SELW-1:0]  wr_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_a_data,
    output logic             rd_a_vld,
    output logic [WIDTH-1:0] rd_b_data,
    output logic             rd_b_vld
);
    typedef struct packed {
        logic [ENTRIES-1:1][WIDTH-1:0] gpr;
    } rf_state_t;

    rf_state_t state_d, state_q;
    logic [ENTRIES-1:0]            wr_hot;
    logic [ENTRIES-1:0][WIDTH-1:0] view;

    rf_wr_decode #(.ENTRIES(ENTRIES), .SELW(SELW)) u_dec (
        .sel(wr_sel), .en(wr_en), .onehot(wr_hot)
    );

    always_comb begin
        state_d = state_q;
        for (int i = 1; i < ENTRIES; i++) begin
            if (wr_hot[i]) state_d.gpr[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_view
            if (g == 0) begin : g_zero
                assign view[g] = '0;
            end else begin : g_reg
                assign view[g] = state_q.gpr[g];
            end
        end
    endgenerate

    rf_read_port #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .SELW(SELW)) u_rda (
        .regs(view), .sel(rd_a_sel), .en(rd_a_en), .data(rd_a_data), .vld(rd_a_vld)
    );
    rf_read_port #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .SELW(SELW)) u_rdb (
        .regs(view), .sel(rd_b_sel), .en(rd_b_en), .data(rd_b_data), .vld(rd_b_vld)
    );

    assert_entry0_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_a_en && rd_a_sel == '0) |-> rd_a_data == '0);
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel != '0 && rd_a_en && rd_a_sel == wr_sel) ##1
        (rd_a_en && $stable(rd_a_sel) && !$past(rst)) |-> rd_a_data == $past(wr_data));
    assert_no_write_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && rd_b_en) ##1 (rd_b_en && $stable(rd_b_sel)) |-> $stable(rd_b_data));
    assert_ports_agree_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_a_en && rd_b_en && rd_a_sel == rd_b_sel) |-> rd_a_data == rd_b_data);
endmodule

// File: tb/tb_dual_bus_regfile.sv
module tb_dual_bus_regfile;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  rd_a_sel, rd_b_sel, wr_sel;
    logic        rd_a_en, rd_b_en, wr_en;
    logic [31:0] wr_data, rd_a_data, rd_b_data;
    logic        rd_a_vld, rd_b_vld;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [31:0] model [8];

    always #10 clk = ~clk;

    dual_bus_regfile dut (
        .clk(clk), .rst(rst),
        .rd_a_sel(rd_a_sel), .rd_a_en(rd_a_en),
        .rd_b_sel(rd_b_sel), .rd_b_en(rd_b_en),
        .wr_sel(wr_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_a_data(rd_a_data), .rd_a_vld(rd_a_vld),
        .rd_b_data(rd_b_data), .rd_b_vld(rd_b_vld)
    );

    task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // read every entry on both ports, comparing with the model
    task automatic sweep(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_a_sel = 3'(i); rd_b_sel = 3'(7 - i); rd_a_en = 1; rd_b_en = 1;
            #1;
            chk(req, {rd_a_vld, rd_a_data}, {1'b1, model[i]});
            chk(req, {rd_b_vld, rd_b_data}, {1'b1, model[7-i]});
        end
    endtask

    task automatic do_write(input logic en, input logic [2:0] d, input logic [31:0] v);
        @(negedge clk);
        wr_en = en; wr_sel = d; wr_data = v;
        @(posedge clk);
        if (en && d != 0) model[d] = v;
        #1;
        wr_en = 0;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1; wr_en = 0; wr_sel = 0; wr_data = 0;
        rd_a_en = 0; rd_b_en = 0; rd_a_sel = 0; rd_b_sel = 0;
        for (int i = 0; i < 8; i++) model[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        sweep("R1");

        // R3/R5: write each entry with a distinct value, then sweep all
        for (int d = 1; d < 8; d++) begin
            do_write(1, 3'(d), 32'h1000_0001 * 32'(d) ^ 32'hA5A5_0000);
            @(negedge clk); sweep("R3_R5");
        end
        // R2: write to entry 0 changes nothing
        do_write(1, 3'd0, 32'hDEAD_BEEF);
        @(negedge clk); sweep("R2");
        // R4: disabled writes to every code change nothing
        for (int d = 0; d < 8; d++) begin
            do_write(0, 3'(d), 32'hFFFF_FFFF);
            @(negedge clk); sweep("R4");
        end
        // R6/R7: disabled ports give zero and a low flag; mixed enables
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd_a_sel = 3'(i); rd_b_sel = 3'(i);
            rd_a_en = 0; rd_b_en = 1; #1;
            chk("R6", {rd_a_vld, rd_a_data}, 33'd0);
            chk("R7", {rd_b_vld, rd_b_data}, {1'b1, model[i]});
            rd_a_en = 1; rd_b_en = 0; #1;
            chk("R6", {rd_a_vld, rd_a_data}, {1'b1, model[i]});
            chk("R7", {rd_b_vld, rd_b_data}, 33'd0);
        end
        // R8: same-cycle read of the written entry returns the old value
        for (int d = 1; d < 8; d++) begin
            @(negedge clk);
            wr_en = 1; wr_sel = 3'(d); wr_data = ~model[d] + 32'(d);
            rd_a_en = 1; rd_a_sel = 3'(d); rd_b_en = 1; rd_b_sel = 3'(d);
            #1;
            chk("R8", {rd_a_vld, rd_a_data}, {1'b1, model[d]});
            chk("R8", {rd_b_vld, rd_b_data}, {1'b1, model[d]});
            @(posedge clk); model[d] = wr_data; #1; wr_en = 0;
            chk("R3", {rd_a_vld, rd_a_data}, {1'b1, model[d]});
        end
        @(negedge clk); sweep("R5");
        // R1: reset clears all entries again
        rst = 1; @(posedge clk); #1; rst = 0;
        for (int i = 0; i < 8; i++) model[i] = 0;
        @(negedge clk); sweep("R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule